// File: doc/BRIEF.md
# I2C Event Status and Interrupt Vector Unit

This unit sits beside an I2C controller core and turns its single-cycle event pulses into sticky status flags. A per-event enable mask selects which flags reach one shared interrupt line. Software can see why the line is high in two ways. It can read the full status word and clear flags by writing ones. It can also read a vector register that returns a small code for the most urgent pending enabled event. Reading the vector acknowledges that event, so a service loop can do nothing but read the vector until it returns zero.

Seven events are tracked: arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, stop detected and addressed-as-slave. Each event has the same bit position in the status and mask words (bits 0 to 6 in that order). The status word also carries two live, read-only levels: receive shift full at bit 11 and bus busy at bit 12. Register access is a plain 16-bit bus with word addresses: 0 is status, 1 is mask, 2 is vector and 3 reads as zero. Read data is combinational from the address.

Top module: `i2c_evt_vector`

## Requirements
- R1: After reset every status flag and every mask bit is zero, the interrupt line is low and the vector reads 0.
- R2: A one-cycle pulse on an event input sets its status bit from the next cycle on. The bit stays set until it is cleared. The positions are: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed-as-slave 6.
- R3: Writing the status address clears each flag whose data bit is 1, starting the next cycle. Data bits that are 0 leave their flags unchanged.
- R4: Status bit 11 shows the receive-shift-full input and bit 12 shows the bus-busy input, both live. Writes cannot change them. Status bits 7 to 10 and 13 to 15 read as zero.
- R5: The mask register holds bits 0 to 6 as written at address 1. Its other bits read as zero. It changes only on a mask write.
- R6: The interrupt output is high exactly when some status flag and its mask bit are both 1.
- R7: The vector register at address 2 returns the code of the pending enabled event with the lowest code. The codes are: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed-as-slave 7. It returns 0 when no enabled flag is set. Events that are pending but masked are never reported.
- R8: A read of the vector register clears the flag of the event it reports, starting the next cycle. No other flag changes. A read that returns 0 clears nothing.
- R9: An event pulse in the same cycle as a clear of that flag leaves the flag set. This holds whether the clear comes from a status write or from a vector read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (acknowledges on a vector read) |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| ev_arb_lost_i | input | 1 | Arbitration-lost pulse |
| ev_nack_i | input | 1 | No-acknowledge pulse |
| ev_acc_rdy_i | input | 1 | Access-ready pulse |
| ev_rx_rdy_i | input | 1 | Receive-ready pulse |
| ev_tx_rdy_i | input | 1 | Transmit-ready pulse |
| ev_stop_i | input | 1 | Stop-detected pulse |
| ev_slv_addr_i | input | 1 | Addressed-as-slave pulse |
| rx_full_i | input | 1 | Receive shift register full level |
| bus_busy_i | input | 1 | Bus busy level |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives an event pulse in the same cycle as a status write that clears its flag, and again in the same cycle as a vector read that reports it. A design that let the clear win would lose that event silently. It drains several pending events through repeated vector reads. A faulty priority order or a missing acknowledge would show up as the wrong code sequence, or as the same code coming back again. It also checks that masked flags stay out of both the vector and the interrupt line, that zero data bits in a status write clear nothing, and that writes leave the live busy and shift-full bits alone. Each of those faults would show up as a wrong status word or as a stray interrupt.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
   localparam int unsigned EVT_N = 7;

   typedef enum logic [1:0] {
      RA_STATUS = 2'd0,
      RA_MASK   = 2'd1,
      RA_VECTOR = 2'd2,
      RA_SPARE  = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   logic [N-1:0] flag_q;

   for (genvar k = 0; k < N; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flag_q[k] <= 1'b0;
         else if (set_i[k])   flag_q[k] <= 1'b1;
         else if (clr_i[k])   flag_q[k] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[k] |=> flag_q[k]);                                   // R9
      AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[k] && !set_i[k]) |=> !flag_q[k]);                   // R3
      AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[k] && !set_i[k]) |=> $stable(flag_q[k]));          // R2
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
   parameter int unsigned N      = 7,
   parameter int unsigned CODE_W = $clog2(N + 1)
) (
   input  logic [N-1:0]      req_i,
   output logic [CODE_W-1:0] code_o,
   output logic [N-1:0]      ack_o
);
   if (N >= (1 << CODE_W)) begin : g_bad_width
      $error("evt_prio_enc: CODE_W too narrow for N");
   end

   always_comb begin
      code_o = '0;
      ack_o  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            code_o = CODE_W'(i + 1);
            ack_o  = '0;
            ack_o[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2c_evt_vector.sv
module i2c_evt_vector
   import i2c_evt_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned RSFULL_POS = 11,
   parameter int unsigned BUSY_POS   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              ev_arb_lost_i,
   input  logic              ev_nack_i,
   input  logic              ev_acc_rdy_i,
   input  logic              ev_rx_rdy_i,
   input  logic              ev_tx_rdy_i,
   input  logic              ev_stop_i,
   input  logic              ev_slv_addr_i,
   input  logic              rx_full_i,
   input  logic              bus_busy_i,
   output logic              irq_o
);
   localparam int unsigned CODE_W = $clog2(EVT_N + 1);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(RA_STATUS);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(RA_MASK);
   localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(RA_VECTOR);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("i2c_evt_vector: ADDR_W must be at least 2");
   end
   if (BUSY_POS >= DATA_W || RSFULL_POS >= DATA_W) begin : g_bad_pos
      $error("i2c_evt_vector: live bit outside data word");
   end
   if (RSFULL_POS < EVT_N || BUSY_POS < EVT_N || RSFULL_POS == BUSY_POS) begin : g_overlap
      $error("i2c_evt_vector: live bits overlap event flags");
   end

   logic [EVT_N-1:0]  ev_set, ev_clr, flags, mask_q, pend, vec_ack;
   logic [CODE_W-1:0] vec_code;
   logic              wr_stat, wr_mask, rd_vec;
   logic              unused_wdata;

   assign ev_set = {ev_slv_addr_i, ev_stop_i, ev_tx_rdy_i, ev_rx_rdy_i,
                    ev_acc_rdy_i, ev_nack_i, ev_arb_lost_i};

   assign wr_stat = wr_en_i && (addr_i == A_STAT);
   assign wr_mask = wr_en_i && (addr_i == A_MASK);
   assign rd_vec  = rd_en_i && (addr_i == A_VEC);
   assign unused_wdata = ^wdata_i[DATA_W-1:EVT_N];

   assign ev_clr = (wr_stat ? wdata_i[EVT_N-1:0] : '0) | (rd_vec ? vec_ack : '0);

   evt_flag_bank #(.N(EVT_N)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ev_set),
      .clr_i  (ev_clr),
      .flag_o (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= wdata_i[EVT_N-1:0];
   end

   assign pend = flags & mask_q;

   evt_prio_enc #(.N(EVT_N), .CODE_W(CODE_W)) u_prio (
      .req_i  (pend),
      .code_o (vec_code),
      .ack_o  (vec_ack)
   );

   assign irq_o = |pend;

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         A_STAT: begin
            rdata_o[EVT_N-1:0]  = flags;
            rdata_o[RSFULL_POS] = rx_full_i;
            rdata_o[BUSY_POS]   = bus_busy_i;
         end
         A_MASK:  rdata_o[EVT_N-1:0]  = mask_q;
         A_VEC:   rdata_o[CODE_W-1:0] = vec_code;
         default: rdata_o = '0;
      endcase
   end

   AST_IRQ_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (vec_code != '0));                                  // R6
   AST_CODE_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_code != '0) |-> irq_o);                                  // R7
   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vec_ack));                                           // R7
   AST_VEC_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vec && ((vec_ack & ev_set) == '0)) |=> (($past(vec_ack) & flags) == '0)); // R8
   AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask |=> $stable(mask_q));                                // R5
endmodule

// File: tb/i2c_evt_vector_bench.sv
`timescale 1ns/1ps
module i2c_evt_vector_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;
   logic [6:0]  ev = 7'd0;
   logic        rx_full = 1'b0, busy = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   bit [6:0] m_flags = 7'd0;
   bit [6:0] m_mask  = 7'd0;

   always #2 clk = ~clk;

   i2c_evt_vector u_i2c_evt_vector (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .ev_arb_lost_i(ev[0]), .ev_nack_i(ev[1]), .ev_acc_rdy_i(ev[2]),
      .ev_rx_rdy_i(ev[3]), .ev_tx_rdy_i(ev[4]), .ev_stop_i(ev[5]),
      .ev_slv_addr_i(ev[6]), .rx_full_i(rx_full), .bus_busy_i(busy),
      .irq_o(irq)
   );

   function automatic int exp_code();
      for (int i = 0; i < 7; i++)
         if (m_flags[i] && m_mask[i]) return i + 1;
      return 0;
   endfunction

   function automatic logic [15:0] exp_read(input logic [1:0] a);
      logic [15:0] v = 16'd0;
      case (a)
         2'd0: begin v[6:0] = m_flags; v[11] = rx_full; v[12] = busy; end
         2'd1: v[6:0] = m_mask;
         2'd2: v = 16'(exp_code());
         default: v = 16'd0;
      endcase
      return v;
   endfunction

   task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // inputs are already driven (negedge side); check outputs, advance one clock, update model
   task automatic tick(input string tag);
      int code;
      #1;
      chk(tag, "irq", {15'd0, irq}, {15'd0, |(m_flags & m_mask)});
      if (rd_en) chk(tag, "rdata", rdata, exp_read(addr));
      code = exp_code();
      @(posedge clk);
      if (wr_en && addr == 2'd0) m_flags &= ~wdata[6:0];
      if (wr_en && addr == 2'd1) m_mask = wdata[6:0];
      if (rd_en && addr == 2'd2 && code != 0) m_flags[code-1] = 1'b0;
      m_flags |= ev;
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      wr_en = 0; rd_en = 0; ev = '0;
      tick(tag);
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      rd_en = 1; wr_en = 0; addr = a;
      tick(tag);
      rd_en = 0; ev = '0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
      wr_en = 1; rd_en = 0; addr = a; wdata = d;
      tick(tag);
      wr_en = 0; ev = '0;
   endtask

   task automatic pulse(input logic [6:0] e, input string tag);
      ev = e;
      idle_keep(tag);
   endtask

   task automatic idle_keep(input string tag);
      wr_en = 0; rd_en = 0;
      tick(tag);
      ev = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");

      // R2 each event alone, mask off: status bit set, no irq (R6)
      for (int i = 0; i < 7; i++) begin
         pulse(7'(1 << i), "R2");
         idle("R6");
         rd(2'd0, "R2");
         wr(2'd0, 16'(1 << i), "R3");
         rd(2'd0, "R3");
      end

      // R3 partial clear, zero bits untouched
      pulse(7'h7F, "R2");
      wr(2'd0, 16'h0000, "R3");
      rd(2'd0, "R3");
      wr(2'd0, 16'h0015, "R3");
      rd(2'd0, "R3");

      // R4 live bits, writes ignored
      busy = 1; rx_full = 0; rd(2'd0, "R4");
      busy = 0; rx_full = 1; rd(2'd0, "R4");
      wr(2'd0, 16'hFF80, "R4");
      busy = 1; rd(2'd0, "R4");
      busy = 0; rx_full = 0;

      // R5 mask readback
      wr(2'd1, 16'hFFFF, "R5"); rd(2'd1, "R5");
      wr(2'd1, 16'h0000, "R5"); rd(2'd1, "R5");

      // R7 masked pending not reported; R6 irq low
      wr(2'd0, 16'h007F, "R3");
      pulse(7'h05, "R2");
      wr(2'd1, 16'h0040, "R7");
      rd(2'd2, "R7");
      wr(2'd1, 16'h0004, "R6");
      rd(2'd2, "R7");

      // R8 drain through vector reads in priority order
      wr(2'd1, 16'h007F, "R5");
      pulse(7'h6A, "R2");
      for (int i = 0; i < 6; i++) rd(2'd2, "R8");
      rd(2'd0, "R8");

      // R9 event with status-write clear of same bit
      pulse(7'h04, "R2");
      ev = 7'h04; wr(2'd0, 16'h0004, "R9");
      rd(2'd0, "R9");
      // R9 event with vector-read acknowledge of same bit
      wr(2'd0, 16'h007F, "R3");
      pulse(7'h01, "R2");
      ev = 7'h01; rd(2'd2, "R9");
      rd(2'd0, "R9");
      rd(2'd2, "R9");
      rd(2'd0, "R8");

      // mixed random traffic, model compared each clock
      for (int n = 0; n < 600; n++) begin
         logic [6:0] e;
         int pick;
         e = '0;
         for (int b = 0; b < 7; b++) if ($urandom_range(0, 7) == 0) e[b] = 1'b1;
         ev = e;
         busy = 1'($urandom_range(0, 1));
         rx_full = 1'($urandom_range(0, 1));
         pick = $urandom_range(0, 9);
         addr = 2'($urandom_range(0, 3));
         wdata = 16'($urandom);
         wr_en = (pick < 2);
         rd_en = (pick >= 4);
         tick("R2/R3/R6/R7/R8 mix");
      end
      wr_en = 0; rd_en = 0; ev = '0;
      idle("R6");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule